// File: doc/BRIEF.md
# Shared-Bus Parallel Flash Access Sequencer

This block lets a host reach a byte-wide parallel flash through a single 8-bit bidirectional bus. Two external 8-bit edge-triggered holding registers keep the access address. The block drives the flash chip-select, read-strobe and write-strobe lines directly. It also drives one clock line per holding register and a shared active-low clear line for both registers. On each access the sequencer first clocks the low and then the high address byte into the holding registers over the shared bus. It then uses the same bus for the data byte, either driving it for a write or releasing it for a read.

A request port accepts one read or write with a 16-bit address and 8-bit write data. The block returns read data and a one-cycle completion pulse. A busy flag covers the whole access. An unlock option runs three writes back to back within one request: the two fixed preamble writes, then a command byte taken from the write-data field. This is the command-entry sequence that byte-wide flash parts expect. Address bit 16 of the flash is assumed tied low on the board, so the reachable window is 64 KB.

Top module: `flash_bus_seq`

## Requirements
- R1: While reset is asserted and for exactly one clock after it is released, the clear line `lat_clr_n` is low. During and after reset, `cs_n`, `rd_n` and `wr_n` are high, `bus_oe` and both holding-register clocks are low, and `busy` is low once the clear cycle ends.
- R2: Each address byte is driven on `bus_out` with `bus_oe` high for at least one clock before its holding-register clock rises, and it stays unchanged while that clock is high. The low byte (address bits 7:0) is loaded before the high byte (bits 15:8). The two clocks are never high together.
- R3: For a write, `wr_n` is low for exactly STROBE_CYC clocks with the data byte on `bus_out` and `bus_oe` high. The byte is still driven when `wr_n` rises. The flash therefore receives the requested 16-bit address and data.
- R4: For a read, `bus_oe` is low for at least one clock before `rd_n` falls. `rd_n` is then low for exactly STROBE_CYC clocks. `rd_data` equals the bus input sampled in the last clock of that window, is valid when `done` pulses, and holds until the next read completes.
- R5: `rd_n` and `wr_n` are never low at the same time, and `bus_oe` is never high while `rd_n` is low.
- R6: `cs_n` goes low before any holding-register clock or strobe is active, stays low for the whole access, and is high whenever the block is idle.
- R7: `done` is a one-clock pulse ending each accepted request. `busy` is high from the clock after acceptance through the `done` clock. A request presented while `busy` is high is ignored and produces no bus activity.
- R8: With `req_unlock` high, one request performs the writes 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/`req_wdata`, in that order. It gives a single `done` pulse, and `cs_n` stays low between the writes.
- R9: Each holding-register clock stays high for exactly STROBE_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_unlock | input | 1 | 1 = three-write unlock sequence (forces write) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data, or command byte of the unlock sequence |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Host drives the shared bus when high |
| bus_in | input | 8 | Value seen on the shared bus |
| cs_n | output | 1 | Flash chip select, active low |
| rd_n | output | 1 | Flash output enable, active low |
| wr_n | output | 1 | Flash write enable, active low |
| lat_lo_clk | output | 1 | Clock of the low-address holding register |
| lat_hi_clk | output | 1 | Clock of the high-address holding register |
| lat_clr_n | output | 1 | Clear of both holding registers, active low |

## Verification
The bench builds the block with STROBE_CYC = 3. At that setting the phase counter has to count through several values rather than expire at once, so the measured widths of the write strobe, the read strobe and both register clocks show whether the counter ends a phase one cycle early or late. Models of the holding registers and the flash sit at the pins. They expose address setup, bus turnaround, strobe overlap and order errors in both the single accesses and the three-write unlock sequence.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_SEL,
    ST_LO_SET,
    ST_LO_CLK,
    ST_HI_SET,
    ST_HI_CLK,
    ST_WR,
    ST_WR_HOLD,
    ST_TURN,
    ST_RD,
    ST_RD_END,
    ST_DONE
  } seq_state_t;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic last
);
  localparam int unsigned CNT_W = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(STROBE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == LAST_V);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (!last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_step_gen.sv
module seq_step_gen
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              unlock,
  input  logic [1:0]        idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] step_addr,
  output logic [DATA_W-1:0] step_data,
  output logic              final_step
);
  always_comb begin
    step_addr  = addr;
    step_data  = wdata;
    final_step = 1'b1;
    if (unlock) begin
      final_step = (idx == 2'd2);
      case (idx)
        2'd0: begin
          step_addr = ADDR_W'(UNLK_ADDR_A);
          step_data = DATA_W'(UNLK_DATA_A);
        end
        2'd1: begin
          step_addr = ADDR_W'(UNLK_ADDR_B);
          step_data = DATA_W'(UNLK_DATA_B);
        end
        default: begin
          step_addr = ADDR_W'(UNLK_ADDR_A);
          step_data = wdata;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_bus_seq.sv
module flash_bus_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_unlock,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              lat_lo_clk,
  output logic              lat_hi_clk,
  output logic              lat_clr_n
);
  localparam int unsigned BYTE_W = ADDR_W / 2;

  logic              rst_i_n;
  seq_state_t        st_q, st_d;
  logic              wr_q, unlk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic [1:0]        idx_q, idx_d;
  logic              accept, phase_last, phase_clr;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;
  logic              final_step;

  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  seq_phase_timer #(.STROBE_CYC(STROBE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .clr(phase_clr), .last(phase_last)
  );

  seq_step_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step (
    .unlock(unlk_q), .idx(idx_q), .addr(addr_q), .wdata(wdata_q),
    .step_addr(step_addr), .step_data(step_data), .final_step(final_step)
  );

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign phase_clr = (st_d != st_q);

  // next-state logic
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_INIT:    st_d = ST_IDLE;
      ST_IDLE:    if (req_valid) begin st_d = ST_SEL; idx_d = 2'd0; end
      ST_SEL:     st_d = ST_LO_SET;
      ST_LO_SET:  st_d = ST_LO_CLK;
      ST_LO_CLK:  if (phase_last) st_d = ST_HI_SET;
      ST_HI_SET:  st_d = ST_HI_CLK;
      ST_HI_CLK:  if (phase_last) st_d = (wr_q || unlk_q) ? ST_WR : ST_TURN;
      ST_WR:      if (phase_last) st_d = ST_WR_HOLD;
      ST_WR_HOLD: begin
        if (final_step) st_d = ST_DONE;
        else begin st_d = ST_LO_SET; idx_d = idx_q + 2'd1; end
      end
      ST_TURN:    st_d = ST_RD;
      ST_RD:      if (phase_last) st_d = ST_RD_END;
      ST_RD_END:  st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // state and request registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_INIT;
      idx_q   <= 2'd0;
      wr_q    <= 1'b0;
      unlk_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (accept) begin
        wr_q    <= req_write;
        unlk_q  <= req_unlock;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (st_q == ST_RD && phase_last) rd_q <= bus_in;
    end
  end

  // output decode
  always_comb begin
    bus_out = '0;
    case (st_q)
      ST_LO_SET, ST_LO_CLK: bus_out = DATA_W'(step_addr[BYTE_W-1:0]);
      ST_HI_SET, ST_HI_CLK: bus_out = DATA_W'(step_addr[ADDR_W-1:BYTE_W]);
      ST_WR, ST_WR_HOLD:    bus_out = step_data;
      default:              bus_out = '0;
    endcase
  end

  assign bus_oe     = (st_q inside {ST_LO_SET, ST_LO_CLK, ST_HI_SET, ST_HI_CLK, ST_WR, ST_WR_HOLD});
  assign cs_n       = (st_q inside {ST_IDLE, ST_INIT, ST_DONE});
  assign rd_n       = (st_q != ST_RD);
  assign wr_n       = (st_q != ST_WR);
  assign lat_lo_clk = (st_q == ST_LO_CLK);
  assign lat_hi_clk = (st_q == ST_HI_CLK);
  assign lat_clr_n  = (st_q != ST_INIT);
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign rd_data    = rd_q;

  // assertions
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!rd_n && !wr_n));
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(bus_oe && !rd_n));
  a_r2_clks_exclusive: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(lat_lo_clk && lat_hi_clk));
  a_r2_lo_setup: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(lat_lo_clk) |-> ($stable(bus_out) && $past(bus_oe)));
  a_r2_hi_setup: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(lat_hi_clk) |-> ($stable(bus_out) && $past(bus_oe)));
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(rd_n) |-> !$past(bus_oe));
  a_r6_select_held: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!wr_n || !rd_n || lat_lo_clk || lat_hi_clk) |-> !cs_n);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> (!done && !busy));
  a_r7_busy_from_req: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(busy) && $past(lat_clr_n)) |-> $past(req_valid));
endmodule

// File: tb/flash_bus_seq_tb.sv
module flash_bus_seq_tb;
  localparam int unsigned STROBE = 3;

  logic       clk;
  logic       rst_n;
  logic       req_valid, req_write, req_unlock;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic       busy, done, bus_oe, cs_n, rd_n, wr_n;
  logic       lat_lo_clk, lat_hi_clk, lat_clr_n;
  logic [7:0] rd_data, bus_out, bus_in;

  int n_chk = 0;
  int n_bad = 0;

  flash_bus_seq #(.ADDR_W(16), .DATA_W(8), .STROBE_CYC(STROBE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_unlock(req_unlock), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .lat_lo_clk(lat_lo_clk), .lat_hi_clk(lat_hi_clk), .lat_clr_n(lat_clr_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // pin-level models of the holding registers and flash
  logic [7:0] lo_q, hi_q;
  logic       run_ok = 1'b0;
  logic [15:0] log_a [0:15];
  logic [7:0]  log_d [0:15];
  int log_n = 0, wr_noe = 0, setup_err = 0, ovl_err = 0, turn_err = 0, sel_err = 0;
  int done_cnt = 0, clr_cnt = 0;
  int we_run = 0, oe_run = 0, lo_run = 0, hi_run = 0;
  int we_w = 0, oe_w = 0, lo_w = 0, hi_w = 0;
  logic [7:0] pn_bus = 8'h00;
  logic       pn_oe = 1'b0, pn_rd_n = 1'b1;

  function automatic logic [7:0] flash_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign bus_in = (!cs_n && !rd_n) ? flash_val({hi_q, lo_q}) : 8'hFF;

  always @(posedge lat_lo_clk or negedge lat_clr_n)
    if (!lat_clr_n) lo_q <= 8'h00; else lo_q <= bus_out;
  always @(posedge lat_hi_clk or negedge lat_clr_n)
    if (!lat_clr_n) hi_q <= 8'h00; else hi_q <= bus_out;

  always @(posedge lat_lo_clk) if (!(bus_out == pn_bus && pn_oe)) setup_err++;
  always @(posedge lat_hi_clk) if (!(bus_out == pn_bus && pn_oe)) setup_err++;

  always @(posedge wr_n) begin
    if (run_ok && !cs_n) begin
      if (!bus_oe) wr_noe++;
      log_a[log_n[3:0]] = {hi_q, lo_q};
      log_d[log_n[3:0]] = bus_out;
      log_n++;
    end
  end

  always @(negedge clk) begin
    if (!lat_clr_n) clr_cnt++;
    if (run_ok) begin
      if (done) done_cnt++;
      if ((!rd_n && !wr_n) || (bus_oe && !rd_n)) ovl_err++;
      if (!rd_n && pn_rd_n && pn_oe) turn_err++;
      if (cs_n && (!rd_n || !wr_n || lat_lo_clk || lat_hi_clk || bus_oe)) sel_err++;
      if (!busy && !cs_n) sel_err++;
      if (!wr_n) we_run++; else if (we_run != 0) begin we_w = we_run; we_run = 0; end
      if (!rd_n) oe_run++; else if (oe_run != 0) begin oe_w = oe_run; oe_run = 0; end
      if (lat_lo_clk) lo_run++; else if (lo_run != 0) begin lo_w = lo_run; lo_run = 0; end
      if (lat_hi_clk) hi_run++; else if (hi_run != 0) begin hi_w = hi_run; hi_run = 0; end
    end
    pn_bus  = bus_out;
    pn_oe   = bus_oe;
    pn_rd_n = rd_n;
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic w, input logic u, input logic [15:0] a,
                       input logic [7:0] d, output int cycles);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_unlock = u; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 0;
    while (!done && cycles < 500) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset;
    chk("R1 clear pulse seen", int'(clr_cnt > 0), 1);
    chk("R1 strobes idle", int'({cs_n, rd_n, wr_n}), 7);
    chk("R1 bus released", int'(bus_oe), 0);
    chk("R1 clocks low", int'({lat_lo_clk, lat_hi_clk}), 0);
    chk("R1 clear released", int'(lat_clr_n), 1);
    chk("R1 not busy", int'(busy), 0);
    chk("R1 registers cleared", int'({hi_q, lo_q}), 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d);
    int c, n0, d0;
    n0 = log_n; d0 = done_cnt;
    issue(1'b1, 1'b0, a, d, c);
    chk("R3 one write", log_n - n0, 1);
    chk("R3 write address", int'(log_a[n0[3:0]]), int'(a));
    chk("R3 write data", int'(log_d[n0[3:0]]), int'(d));
    chk("R3 we width", we_w, STROBE);
    chk("R9 lo clock width", lo_w, STROBE);
    chk("R9 hi clock width", hi_w, STROBE);
    chk("R7 busy during done", int'(busy), 1);
    @(negedge clk);
    chk("R7 single done", done_cnt - d0, 1);
    chk("R6 idle deselected", int'(cs_n), 1);
  endtask

  task automatic t_read(input logic [15:0] a);
    int c, n0;
    n0 = log_n;
    issue(1'b0, 1'b0, a, 8'h00, c);
    chk("R4 read data", int'(rd_data), int'(flash_val(a)));
    chk("R4 oe width", oe_w, STROBE);
    chk("R2 address loaded", int'({hi_q, lo_q}), int'(a));
    chk("R4 no write on read", log_n - n0, 0);
    repeat (3) @(negedge clk);
    chk("R4 read data held", int'(rd_data), int'(flash_val(a)));
  endtask

  task automatic t_unlock(input logic [7:0] cmd);
    int c, n0, d0;
    n0 = log_n; d0 = done_cnt;
    issue(1'b0, 1'b1, 16'hBEEF, cmd, c);
    @(negedge clk);
    chk("R8 three writes", log_n - n0, 3);
    chk("R8 first addr", int'(log_a[n0[3:0]]), 16'h5555);
    chk("R8 first data", int'(log_d[n0[3:0]]), 8'hAA);
    chk("R8 second addr", int'(log_a[(n0 + 1) % 16]), 16'h2AAA);
    chk("R8 second data", int'(log_d[(n0 + 1) % 16]), 8'h55);
    chk("R8 third addr", int'(log_a[(n0 + 2) % 16]), 16'h5555);
    chk("R8 third data", int'(log_d[(n0 + 2) % 16]), int'(cmd));
    chk("R8 single done", done_cnt - d0, 1);
  endtask

  task automatic t_busy_ignore;
    int n0, d0, cyc;
    n0 = log_n; d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_unlock = 1'b0;
    req_addr = 16'h0F0F; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 16'h1234; req_wdata = 8'h99;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 500) begin @(negedge clk); cyc++; end
    repeat (10) @(negedge clk);
    chk("R7 ignored while busy", log_n - n0, 1);
    chk("R7 first request kept addr", int'(log_a[n0[3:0]]), 16'h0F0F);
    chk("R7 first request kept data", int'(log_d[n0[3:0]]), 8'h11);
    chk("R7 one done", done_cnt - d0, 1);
    chk("R7 idle after", int'(busy), 0);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_unlock = 1'b0;
    req_addr = '0; req_wdata = '0;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    run_ok = 1'b1;
    t_reset();
    t_write(16'hA55A, 8'h3E);
    t_read(16'hA55A);
    t_write(16'h0001, 8'hFF);
    t_read(16'hFFFF);
    t_read(16'h0000);
    t_unlock(8'h90);
    t_unlock(8'hF0);
    t_busy_ignore();
    chk("R2 setup violations", setup_err, 0);
    chk("R3 data driven at we rise", wr_noe, 0);
    chk("R5 overlap or contention", ovl_err, 0);
    chk("R4 turnaround violations", turn_err, 0);
    chk("R6 select order violations", sel_err, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule